// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block provides three independent 16-bit down-counters. They share one control-word port and one 8-bit write bus. Each channel has its own write strobe and read strobe. A control word selects a channel and does one of two things: it programs the channel's operating mode, or it freezes a snapshot of the channel's count. Software loads a channel by writing two bytes, low first and high second. The high-byte write starts the countdown. The counter then decrements once on every clock cycle in which the count-enable tick is high. In the nominal system that tick runs at 1 193 180 Hz.

Each channel drives an output level. Channel 2's level also appears as the speaker bit of an 8-bit status byte. An illegal control word is ignored, and it sets a sticky error flag that only reset clears.

Top module: `pit_timer`

## Requirements
- R1: After synchronous reset, every channel output, the status byte, the read data and the error flag are 0, and every count reads back as 0x0000.
- R2: The control word is decoded as follows: bits 7:6 channel select, bits 5:4 access, bits 3:1 mode, bit 0 BCD. The following words are illegal: select 3, access 01 or 10, BCD 1, or (for access 11) a mode other than 0, 2 or 3. An illegal word sets the sticky error flag and leaves every channel unchanged.
- R3: Access 00 is a latch command. If the channel is not latched, it copies the current count into a snapshot and resets the read pointer to the low byte. If the channel is already latched, the command is ignored and the first snapshot is kept.
- R4: Each read strobe returns one byte on `rd_data` in the cycle after the strobe. Reads alternate low byte then high byte. While a snapshot is held, reads return the snapshot, and reading its high byte releases the latch. Otherwise reads return the live count.
- R5: A low-byte write replaces count bits 7:0, stops any countdown and drives the channel output low.
- R6: A high-byte write replaces count bits 15:8 and takes the 16-bit value as the period. The countdown starts only if that period is non-zero; a zero period leaves the channel idle.
- R7: A running count decrements only in cycles where `tick_en` is 1. In mode 0, the output goes high on the Nth tick after a load of N, and the count stays at 0.
- R8: In modes 2 and 3, expiry reloads the period and counting continues. The output level does not change.
- R9: Bit 5 of `status_byte` equals channel 2's output. All other status bits are 0.
- R10: Channels are independent: one channel's writes, reads, latches and expiry do not affect another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-enable tick |
| ctrl_wr | input | 1 | Control-word write strobe |
| ctrl_data | input | 8 | Control word |
| wr_en | input | 3 | Per-channel data write strobes |
| wr_data | input | 8 | Data byte to write |
| rd_en | input | 3 | Per-channel data read strobes (lowest index wins) |
| rd_data | output | 8 | Byte read, valid the cycle after the strobe |
| chan_out | output | 3 | Per-channel output level |
| status_byte | output | 8 | Status byte, bit 5 = channel 2 output |
| err | output | 1 | Sticky illegal-control-word flag |

## Verification
Each scenario drives the countdown with a burst of ticks of a chosen length and then stops the ticks before any read. This makes the live count exact, so an off-by-one in the expiry cycle shows up as an output that is wrong one tick early or one tick late. The snapshot test lets the count move on after the latch and then issues a second latch. Live reads return a different value from the snapshot, so the test tells apart a snapshot that was lost, one that was re-taken and one that was released too early. Loads of 0, 2, 3, 5 and 0x0110 in modes 0 and 2 separate these three behaviours: a one-shot stop, a periodic reload and a channel that stays idle. Illegal words are followed by a load, so the test can show that the channel kept its mode.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_WORD  = 2'b11
    } acc_e;

    typedef struct packed {
        logic [1:0] sel;
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_word_t;

    typedef struct packed {
        logic       latch;
        logic       cfg;
        logic [2:0] mode;
    } chan_cmd_t;

    localparam logic [2:0] MODE_TC   = 3'd0;
    localparam logic [2:0] MODE_RATE = 3'd2;
    localparam logic [2:0] MODE_SQ   = 3'd3;

    function automatic logic mode_ok(input logic [2:0] m);
        return (m == MODE_TC) || (m == MODE_RATE) || (m == MODE_SQ);
    endfunction

endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
    import pit_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ctrl_wr,
    input  logic [7:0]            ctrl_data,
    output chan_cmd_t [NCH-1:0]   cmd,
    output logic                  err
);
    ctrl_word_t cw;
    logic       sel_ok;
    logic       legal;

    assign cw     = ctrl_word_t'(ctrl_data);
    assign sel_ok = (32'(cw.sel) < NCH) && (cw.sel != 2'd3);

    always_comb begin
        legal = 1'b0;
        if (sel_ok) begin
            if (cw.acc == ACC_LATCH)
                legal = 1'b1;
            else if (cw.acc == ACC_WORD && !cw.bcd && mode_ok(cw.mode))
                legal = 1'b1;
        end
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_cmd
            always_comb begin
                cmd[c].latch = ctrl_wr && legal && (32'(cw.sel) == c) && (cw.acc == ACC_LATCH);
                cmd[c].cfg   = ctrl_wr && legal && (32'(cw.sel) == c) && (cw.acc == ACC_WORD);
                cmd[c].mode  = cw.mode;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            err <= 1'b0;
        else if (ctrl_wr && !legal)
            err <= 1'b1;
    end

    a_r2_err_sticky: assert property (@(posedge clk) disable iff (rst) err |=> err);
    a_r2_bad_word_sets_err: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && cw.sel == 2'd3) |=> err);

endmodule

// File: rtl/pit_chan.sv
module pit_chan
    import pit_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  chan_cmd_t     cmd,
    input  logic          wr_en,
    input  logic [CW/2-1:0] wr_data,
    input  logic          rd_en,
    output logic [CW/2-1:0] rd_byte,
    output logic          out_q
);
    localparam int BW = CW / 2;

    logic [CW-1:0] count, snap, period;
    logic [2:0]    mode;
    logic          latched, rd_hi, wr_hi, running;
    logic [CW-1:0] rd_src;
    logic          expire;

    assign rd_src  = latched ? snap : count;
    assign rd_byte = rd_hi ? rd_src[CW-1:BW] : rd_src[BW-1:0];
    assign expire  = running && tick_en && (count == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            snap    <= '0;
            period  <= '0;
            mode    <= MODE_TC;
            latched <= 1'b0;
            rd_hi   <= 1'b0;
            wr_hi   <= 1'b0;
            running <= 1'b0;
            out_q   <= 1'b0;
        end else begin
            if (cmd.cfg)
                mode <= cmd.mode;

            if (cmd.latch && !latched) begin
                snap    <= count;
                latched <= 1'b1;
                rd_hi   <= 1'b0;
            end else if (rd_en) begin
                rd_hi <= !rd_hi;
                if (rd_hi && latched)
                    latched <= 1'b0;
            end

            if (wr_en) begin
                if (!wr_hi) begin
                    count[BW-1:0] <= wr_data;
                    running       <= 1'b0;
                    out_q         <= 1'b0;
                    wr_hi         <= 1'b1;
                end else begin
                    count[CW-1:BW] <= wr_data;
                    period         <= {wr_data, count[BW-1:0]};
                    running        <= ({wr_data, count[BW-1:0]} != '0);
                    wr_hi          <= 1'b0;
                end
            end else if (expire) begin
                if (mode == MODE_TC) begin
                    count   <= '0;
                    running <= 1'b0;
                    out_q   <= 1'b1;
                end else begin
                    count <= period;
                end
            end else if (running && tick_en) begin
                count <= count - CW'(1);
            end
        end
    end

    a_r5_low_write_stops: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_hi) |=> (!out_q && !running));
    a_r6_zero_period_idle: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_hi && {wr_data, count[BW-1:0]} == '0) |=> !running);
    a_r3_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (latched && !(rd_en && rd_hi)) |=> (latched && $stable(snap)));
    a_r4_pointer_toggles: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !(cmd.latch && !latched)) |=> (rd_hi != $past(rd_hi)));
    a_r7_mode0_expiry: assert property (@(posedge clk) disable iff (rst)
        (expire && mode == MODE_TC && !wr_en && !cmd.cfg) |=> (out_q && count == '0));
    a_r7_no_tick_no_change: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !wr_en) |=> $stable(count));
    a_r8_periodic_reload: assert property (@(posedge clk) disable iff (rst)
        (expire && mode != MODE_TC && !wr_en && !cmd.cfg) |=> (count == period && $stable(out_q)));

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int NCH      = 3,
    parameter int CW       = 16,
    parameter int SPKR_CH  = 2,
    parameter int SPKR_BIT = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick_en,
    input  logic           ctrl_wr,
    input  logic [7:0]     ctrl_data,
    input  logic [NCH-1:0] wr_en,
    input  logic [7:0]     wr_data,
    input  logic [NCH-1:0] rd_en,
    output logic [7:0]     rd_data,
    output logic [NCH-1:0] chan_out,
    output logic [7:0]     status_byte,
    output logic           err
);
    localparam int BW = CW / 2;

    chan_cmd_t [NCH-1:0] cmd;
    logic [BW-1:0]       byte_of [NCH];
    logic [BW-1:0]       rd_pick;
    logic [NCH-1:0]      rd_gnt;

    pit_ctrl_decode #(.NCH(NCH)) u_dec (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
        .cmd(cmd), .err(err)
    );

    always_comb begin
        rd_gnt = '0;
        for (int c = 0; c < NCH; c++)
            if (rd_en[c] && rd_gnt == '0)
                rd_gnt[c] = 1'b1;
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            pit_chan #(.CW(CW)) u_ch (
                .clk(clk), .rst(rst), .tick_en(tick_en), .cmd(cmd[c]),
                .wr_en(wr_en[c]), .wr_data(wr_data[BW-1:0]),
                .rd_en(rd_gnt[c]), .rd_byte(byte_of[c]), .out_q(chan_out[c])
            );
        end
    endgenerate

    always_comb begin
        rd_pick = '0;
        for (int c = 0; c < NCH; c++)
            if (rd_gnt[c])
                rd_pick = byte_of[c];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en != '0)
            rd_data <= 8'(rd_pick);
    end

    always_comb begin
        status_byte = '0;
        status_byte[SPKR_BIT] = chan_out[SPKR_CH];
    end

    a_r4_read_one_hot: assert property (@(posedge clk) disable iff (rst) $onehot0(rd_gnt));
    a_r1_reset_clears: assert property (@(posedge clk) $past(rst) |-> (chan_out == '0 && !err && rd_data == '0));

endmodule

// File: tb/test_pit_timer.sv
module test_pit_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_data = '0;
    logic [2:0] wr_en = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_en = '0;
    logic [7:0] rd_data;
    logic [2:0] chan_out;
    logic [7:0] status_byte;
    logic       err;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    pit_timer i_pit_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .chan_out(chan_out), .status_byte(status_byte), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic ctrl(input logic [7:0] w);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_data = w;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic wr(input int ch, input logic [7:0] d);
        @(negedge clk); wr_en = 3'(1 << ch); wr_data = d;
        @(negedge clk); wr_en = '0;
    endtask

    task automatic load(input int ch, input logic [15:0] v);
        wr(ch, v[7:0]); wr(ch, v[15:8]);
    endtask

    task automatic rd(input int ch, output logic [7:0] b);
        @(negedge clk); rd_en = 3'(1 << ch);
        @(negedge clk); rd_en = '0; b = rd_data;
    endtask

    task automatic rd16(input int ch, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(ch, lo); rd(ch, hi); v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick_en = 1'b1;
        for (int i = 0; i < n - 1; i++) @(negedge clk);
        @(negedge clk); tick_en = 1'b0;
    endtask

    // ticks(n): tick_en sampled high at exactly n posedges
    task automatic run_ticks(input int n);
        tick_en = 1'b1;
        for (int i = 0; i < n; i++) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        check("R1 chan_out", 32'(chan_out), 0);
        check("R1 err", 32'(err), 0);
        check("R1 status", 32'(status_byte), 0);
        check("R1 rd_data", 32'(rd_data), 0);
        rd16(0, v); check("R1 count0", 32'(v), 0);
    endtask

    task automatic t_mode0();
        logic [15:0] v;
        do_reset();
        ctrl(8'h30);
        load(0, 16'd5);
        rd16(0, v); check("R6 loaded count", 32'(v), 5);
        @(negedge clk); run_ticks(4);
        check("R7 before expiry", 32'(chan_out[0]), 0);
        rd16(0, v); check("R7 count after 4 ticks", 32'(v), 1);
        run_ticks(1);
        check("R7 mode0 expiry", 32'(chan_out[0]), 1);
        run_ticks(3);
        rd16(0, v); check("R7 stays at zero", 32'(v), 0);
        wr(0, 8'h09);
        check("R5 low write drops out", 32'(chan_out[0]), 0);
        run_ticks(3);
        rd16(0, v); check("R5 countdown stopped", 32'(v), 16'h0009);
    endtask

    task automatic t_latch_mode2();
        logic [15:0] v;
        do_reset();
        ctrl(8'h74);
        load(1, 16'h0110);
        run_ticks(16);
        ctrl(8'h40);
        run_ticks(5);
        ctrl(8'h40);
        rd16(1, v); check("R3 snapshot kept", 32'(v), 16'h0100);
        rd16(1, v); check("R4 live after release", 32'(v), 16'h00FB);
        check("R10 ch0 untouched", 32'(chan_out), 0);
        load(1, 16'd3);
        run_ticks(2);
        rd16(1, v); check("R8 count before reload", 32'(v), 1);
        run_ticks(1);
        rd16(1, v); check("R8 reloaded period", 32'(v), 3);
        check("R8 out unchanged", 32'(chan_out[1]), 0);
    endtask

    task automatic t_errors();
        logic [15:0] v;
        do_reset();
        ctrl(8'hC0);
        check("R2 select 3 error", 32'(err), 1);
        ctrl(8'h30);
        check("R2 error sticky", 32'(err), 1);
        do_reset();
        ctrl(8'h10);
        check("R2 access 01 error", 32'(err), 1);
        do_reset();
        ctrl(8'h3A);
        check("R2 mode 5 error", 32'(err), 1);
        do_reset();
        ctrl(8'h37);
        check("R2 bcd error", 32'(err), 1);
        load(0, 16'd2);
        run_ticks(2);
        check("R2 mode unchanged by bad word", 32'(chan_out[0]), 1);
    endtask

    task automatic t_zero_and_speaker();
        logic [15:0] v;
        do_reset();
        ctrl(8'h30);
        load(0, 16'd0);
        run_ticks(5);
        check("R6 zero period idle", 32'(chan_out[0]), 0);
        rd16(0, v); check("R6 zero count", 32'(v), 0);
        ctrl(8'hB0);
        load(2, 16'd1);
        check("R9 before", 32'(status_byte), 0);
        run_ticks(1);
        check("R9 speaker bit", 32'(status_byte), 32'h20);
        check("R10 only ch2", 32'(chan_out), 32'b100);
        check("R2 valid words no error", 32'(err), 0);
    endtask

    initial begin : wd
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) disable wd;
        end
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_mode0();
        t_latch_mode2();
        t_errors();
        t_zero_and_speaker();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule